// File: doc/BRIEF.md
# GPIO Interrupt Cause Controller

This block watches a bank of general-purpose input pins and turns their activity into a small set of grouped interrupt requests for an upstream interrupt controller. Every pin is first brought into the clock domain by a two-flop synchroniser. It is then optionally inverted by a per-pin polarity bit, and the result is the pin's data-in value.

Each data-in bit feeds two independent paths. The level path uses the data-in bit directly as a cause. The edge path latches a 0-to-1 transition of the data-in bit into a sticky cause bit that software clears. Each path has its own mask. Both contributions are gated off for pins configured as outputs. The per-pin totals are ORed in groups of eight, and each group drives one registered interrupt output.

Software reaches six registers over a single-cycle write strobe and a combinational read port. To choose which pin edge triggers the edge path, software sets the polarity bit. With polarity 0 a rising pin edge is caught; with polarity 1 a falling pin edge is caught.

Top module: `gpio_irq_cause`

## Requirements
- R1: Register address 0 reads data-in, which is the synchronised pin value XOR the polarity register (address 1). A polarity bit of 0 passes the pin through and a polarity bit of 1 inverts it. Writes to address 0 are ignored.
- R2: A pin's level contribution is data-in AND level mask (address 3). It is not latched, so when data-in returns to 0 the contribution drops.
- R3: A 0-to-1 change of a data-in bit sets the matching bit of the edge cause register (address 5). That bit stays set after data-in falls again, until software clears it.
- R4: A pin's edge contribution is edge cause AND edge mask (address 4). Clearing the mask bit removes the contribution but leaves the cause bit intact.
- R5: A polarity write that makes data-in rise does not set an edge cause bit. With polarity 1, a falling pin edge sets the cause bit.
- R6: A write to address 5 clears each cause bit whose write data bit is 0 and keeps each bit written as 1. An edge that arrives in the same cycle as the clear leaves its bit set.
- R7: Output bit g is the OR of the total causes of pins 8g to 8g+7. A pin's total cause is its level contribution OR its edge contribution.
- R8: The direction register (address 2) marks a pin as an input with bit value 1. For a pin with bit value 0, both of its contributions are zero.
- R9: After reset, the polarity, direction, level mask, edge mask and edge cause registers all read 0, and all group outputs are 0.
- R10: A pin change reaches a group output through the level path on the third rising clock edge after it is applied. Through the edge path it arrives on the fourth.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NPINS | Raw asynchronous pin levels |
| reg_wr | input | 1 | Single-cycle write strobe |
| reg_addr | input | AW | Register address (0 data-in, 1 polarity, 2 direction, 3 level mask, 4 edge mask, 5 edge cause) |
| reg_wdata | input | NPINS | Write data |
| reg_rdata | output | NPINS | Combinational read data |
| grp_irq_o | output | NPINS/GRP_W | Registered grouped interrupt requests |

## Verification
The bench builds the block with its defaults: 32 pins in groups of eight, so there are four group outputs. With these values the group boundary pins 7, 8, 16 and 31 can all be exercised, and every output bit can be checked. The table-driven part sweeps polarity and level mask combinations across all four groups. The directed part then covers the edge cause cases:
- a rise of data-in caused by a polarity write;
- a clear in the same cycle as a new edge;
- gating by the direction register;
- the exact synchroniser and output register latency.

// File: rtl/gpio_irq_cause.sv
module gpio_irq_cause #(
  parameter int NPINS = 32,
  parameter int GRP_W = 8,
  parameter int AW    = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NPINS-1:0]         pin_i,
  input  logic                     reg_wr,
  input  logic [AW-1:0]            reg_addr,
  input  logic [NPINS-1:0]         reg_wdata,
  output logic [NPINS-1:0]         reg_rdata,
  output logic [NPINS/GRP_W-1:0]   grp_irq_o
);

  localparam int NGRP = NPINS / GRP_W;
  localparam logic [AW-1:0] A_DIN  = AW'(0);
  localparam logic [AW-1:0] A_POL  = AW'(1);
  localparam logic [AW-1:0] A_DIR  = AW'(2);
  localparam logic [AW-1:0] A_LMSK = AW'(3);
  localparam logic [AW-1:0] A_EMSK = AW'(4);
  localparam logic [AW-1:0] A_ECAU = AW'(5);

  logic [NPINS-1:0] sync1, sync2, sync_prev;
  logic [NPINS-1:0] pol, dir, lmask, emask, ecause;
  logic [NPINS-1:0] din, din_prev, edge_vec, cause;
  logic [NGRP-1:0]  grp_or;

  // both samples use the current polarity, so a polarity write never looks like an edge
  assign din      = sync2 ^ pol;
  assign din_prev = sync_prev ^ pol;
  assign edge_vec = din & ~din_prev;
  assign cause    = ((din & lmask) | (ecause & emask)) & dir;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1     <= '0;
      sync2     <= '0;
      sync_prev <= '0;
    end else begin
      sync1     <= pin_i;
      sync2     <= sync1;
      sync_prev <= sync2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol   <= '0;
      dir   <= '0;
      lmask <= '0;
      emask <= '0;
    end else if (reg_wr) begin
      if (reg_addr == A_POL)  pol   <= reg_wdata;
      if (reg_addr == A_DIR)  dir   <= reg_wdata;
      if (reg_addr == A_LMSK) lmask <= reg_wdata;
      if (reg_addr == A_EMSK) emask <= reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ecause <= '0;
    else if (reg_wr && reg_addr == A_ECAU)
      ecause <= (ecause & reg_wdata) | edge_vec;
    else
      ecause <= ecause | edge_vec;
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign grp_or[g] = |cause[g*GRP_W +: GRP_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) grp_irq_o <= '0;
    else        grp_irq_o <= grp_or;
  end

  always_comb begin
    case (reg_addr)
      A_DIN:   reg_rdata = din;
      A_POL:   reg_rdata = pol;
      A_DIR:   reg_rdata = dir;
      A_LMSK:  reg_rdata = lmask;
      A_EMSK:  reg_rdata = emask;
      A_ECAU:  reg_rdata = ecause;
      default: reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/gpio_irq_cause_chk.sv
module gpio_irq_cause_chk #(
  parameter int NPINS = 32,
  parameter int GRP_W = 8,
  parameter int AW    = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   reg_wr,
  input logic [AW-1:0]          reg_addr,
  input logic [NPINS-1:0]       reg_wdata,
  input logic [NPINS-1:0]       edge_vec,
  input logic [NPINS-1:0]       ecause,
  input logic [NPINS-1:0]       cause,
  input logic [NPINS-1:0]       dir,
  input logic [NPINS/GRP_W-1:0] grp_irq_o
);

  localparam logic [AW-1:0] A_ECAU = AW'(5);

  p_edge_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|edge_vec) |=> ((ecause & $past(edge_vec)) == $past(edge_vec)));

  p_cause_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == A_ECAU) |=> ((ecause & $past(ecause)) == $past(ecause)));

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_ECAU) |=>
      ((ecause & ~$past(reg_wdata) & ~$past(edge_vec)) == '0));

  p_idle_groups_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cause == '0) |=> (grp_irq_o == '0));

  p_outputs_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dir == '0) |=> (grp_irq_o == '0));

  p_reset_r9: assert property (@(posedge clk)
    !rst_n |=> (ecause == '0 && grp_irq_o == '0));

endmodule

bind gpio_irq_cause gpio_irq_cause_chk #(.NPINS(NPINS), .GRP_W(GRP_W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .edge_vec(edge_vec), .ecause(ecause),
  .cause(cause), .dir(dir), .grp_irq_o(grp_irq_o)
);

// File: tb/gpio_irq_cause_test.sv
module gpio_irq_cause_test;
  localparam int CLK_PERIOD = 10;
  localparam int NPINS = 32;
  localparam int NGRP  = 4;
  localparam logic [2:0] A_DIN = 3'd0, A_POL = 3'd1, A_DIR = 3'd2,
                         A_LMSK = 3'd3, A_EMSK = 3'd4, A_ECAU = 3'd5;

  // {pins, polarity, level mask, expected data-in, expected groups}
  localparam logic [131:0] VEC [9] = '{
    {32'h0000_0001, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0001, 4'b0001},
    {32'h0000_0000, 32'h0000_0100, 32'hFFFF_FFFF, 32'h0000_0100, 4'b0010},
    {32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000, 4'b0000},
    {32'h8000_0000, 32'h0000_0000, 32'h7FFF_FFFF, 32'h8000_0000, 4'b0000},
    {32'h0001_0000, 32'h0000_0000, 32'h0001_0000, 32'h0001_0000, 4'b0100},
    {32'h1234_5678, 32'h0F0F_0F0F, 32'hFF00_00FF, 32'h1D3B_5977, 4'b1001},
    {32'h0000_0000, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000, 4'b0000},
    {32'h0000_0080, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0080, 4'b0001},
    {32'h8000_0000, 32'h0000_0000, 32'hFFFF_FFFF, 32'h8000_0000, 4'b1000}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NPINS-1:0] pin_i = '0;
  logic             reg_wr = 1'b0;
  logic [2:0]       reg_addr = '0;
  logic [NPINS-1:0] reg_wdata = '0;
  logic [NPINS-1:0] reg_rdata;
  logic [NGRP-1:0]  grp_irq_o;

  int n_tests = 0;
  int n_fail  = 0;
  logic [NPINS-1:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_cause uut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .grp_irq_o(grp_irq_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [NPINS-1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [NPINS-1:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic set_pins(input logic [NPINS-1:0] v);
    @(negedge clk);
    pin_i = v;
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    settle(3);
    rst_n = 1'b1;
    settle(1);
    // R9 reset state
    rd(A_POL, rv);  chk("R9 polarity", rv, 0);
    rd(A_DIR, rv);  chk("R9 direction", rv, 0);
    rd(A_LMSK, rv); chk("R9 level mask", rv, 0);
    rd(A_EMSK, rv); chk("R9 edge mask", rv, 0);
    rd(A_ECAU, rv); chk("R9 edge cause", rv, 0);
    chk("R9 groups", 32'(grp_irq_o), 0);

    wr(A_DIR, '1);
    for (int i = 0; i < 9; i++) begin
      wr(A_POL, VEC[i][99:68]);
      wr(A_LMSK, VEC[i][67:36]);
      set_pins(VEC[i][131:100]);
      settle(4);
      rd(A_DIN, rv); chk($sformatf("R1 data-in vec %0d", i), rv, VEC[i][35:4]);
      chk($sformatf("R2/R7 groups vec %0d", i), 32'(grp_irq_o), 32'(VEC[i][3:0]));
    end
    wr(A_DIN, 32'hFFFF_FFFF);
    rd(A_DIN, rv); chk("R1 data-in write ignored", rv, 32'h8000_0000);

    // R10 level latency
    wr(A_LMSK, 32'h8000_0000); set_pins('0); settle(4);
    @(negedge clk); pin_i = 32'h8000_0000;
    @(posedge clk); @(posedge clk); #1;
    chk("R10 level not yet", 32'(grp_irq_o), 0);
    @(posedge clk); #1;
    chk("R10 level third edge", 32'(grp_irq_o), 32'h8);

    // R10 edge latency
    wr(A_LMSK, '0); set_pins('0); settle(4);
    wr(A_ECAU, '0); wr(A_EMSK, 32'h8000_0000);
    @(negedge clk); pin_i = 32'h8000_0000;
    repeat (3) @(posedge clk); #1;
    chk("R10 edge not yet", 32'(grp_irq_o), 0);
    @(posedge clk); #1;
    chk("R10 edge fourth edge", 32'(grp_irq_o), 32'h8);

    // R3/R4 sticky cause and edge mask
    set_pins('0); settle(4);
    wr(A_ECAU, '0); wr(A_EMSK, 32'h8); settle(2);
    set_pins(32'h8); settle(5);
    rd(A_ECAU, rv); chk("R3 rise sets cause", rv, 32'h8);
    chk("R4 edge group", 32'(grp_irq_o), 32'h1);
    set_pins('0); settle(5);
    rd(A_ECAU, rv); chk("R3 cause sticky", rv, 32'h8);
    chk("R3 group held", 32'(grp_irq_o), 32'h1);
    wr(A_EMSK, '0); settle(2);
    chk("R4 masked group", 32'(grp_irq_o), 0);
    rd(A_ECAU, rv); chk("R4 cause kept under mask", rv, 32'h8);
    wr(A_EMSK, 32'h8);

    // R6 write-one keeps, write-zero clears
    wr(A_ECAU, '1);
    rd(A_ECAU, rv); chk("R6 ones keep", rv, 32'h8);
    wr(A_ECAU, 32'hFFFF_FFF7); settle(2);
    rd(A_ECAU, rv); chk("R6 zero clears", rv, 0);
    chk("R6 group after clear", 32'(grp_irq_o), 0);

    // R5 polarity writes create no edge, falling edge via polarity
    wr(A_POL, 32'h200); settle(3);
    rd(A_DIN, rv); chk("R5 data-in by polarity", rv, 32'h200);
    rd(A_ECAU, rv); chk("R5 no edge from polarity", rv, 0);
    set_pins(32'h200); settle(5);
    rd(A_ECAU, rv); chk("R5 pin rise ignored at pol 1", rv, 0);
    wr(A_POL, '0); settle(3);
    rd(A_ECAU, rv); chk("R5 no edge from polarity clear", rv, 0);
    wr(A_POL, 32'h200);
    set_pins('0); settle(5);
    rd(A_ECAU, rv); chk("R5 falling pin edge caught", rv, 32'h200);

    // R6 edge wins over same-cycle clear
    @(negedge clk); pin_i = 32'h0010_0000;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b1; reg_addr = A_ECAU; reg_wdata = '0;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
    rd(A_ECAU, rv); chk("R6 edge wins over clear", rv, 32'h0010_0000);

    // R8 direction gating
    wr(A_ECAU, '0); wr(A_POL, '0); wr(A_EMSK, '0);
    set_pins('0); settle(4);
    wr(A_DIR, 32'hFFFF_FFFE); wr(A_LMSK, 32'h1); wr(A_EMSK, 32'h1);
    set_pins(32'h1); settle(5);
    chk("R8 output pin gated", 32'(grp_irq_o), 0);
    wr(A_DIR, '1); settle(2);
    chk("R8 input pin passes", 32'(grp_irq_o), 32'h1);
    wr(A_LMSK, '0); settle(2);
    chk("R8 edge path after enable", 32'(grp_irq_o), 32'h1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule